// File: doc/BRIEF.md
# GMII Frame Receiver with FCS Check

This block sits on an 8-bit GMII-style receive path and takes in one Ethernet frame at a time. The frame starts at the first clock edge where valid is seen high. It ends at the first edge after that where valid is seen low. Each byte is placed by its position in the frame. The block captures the destination address, the source address and the length field. It streams the payload bytes to a client. It recomputes the CRC-32 over the covered region and compares it with the four trailing check bytes.

When a frame ends, the block raises a one-cycle end strobe. Three status flags come with it. The first says whether the check sequence matched. The second says whether the frame is bad: an error was seen on the line, the frame was too short, or the payload size disagreed with the length field. The third says whether the preamble or the start delimiter was malformed. A running counter records how many frames have completed.

The payload passes through a four-byte tail buffer. This means the check bytes never reach the client, even though the frame length is unknown until valid drops.

Top module: `gmii_frame_rx`

## Requirements
- R1: A frame begins at the first rising edge that samples `rx_dv` high while idle. That byte is index 0, and each later edge with `rx_dv` high takes the next index. Indices 0-6 are preamble, 7 is the start delimiter, 8-13 the destination address, 14-19 the source address, 20-21 the length field, then payload, and the last four bytes are the check sequence.
- R2: The first edge that samples `rx_dv` low after a frame has begun ends the frame. `frame_end` is high for exactly the one cycle following that edge.
- R3: While `frame_end` is high, `dst_addr` and `src_addr` hold their six bytes with the earliest received byte in bits 47:40. `len_field` holds byte 20 in bits 15:8 and byte 21 in bits 7:0.
- R4: Each payload byte (index 22 up to the fifth-last byte) appears once on `pay_data` with `pay_valid` high, in order. It appears in the cycle after the edge that samples the byte four positions later. Check-sequence bytes never appear.
- R5: The CRC-32 uses the reflected polynomial 0xEDB88320 and is seeded with all ones. It runs over index 8 through the fifth-last byte. Its one's complement must equal the last four bytes, read with the first of them as bits 7:0. When it does, `fcs_ok` is high with `frame_end`; otherwise it is low.
- R6: `preamble_bad` is high with `frame_end` when any of bytes 0-6 differs from 0x55 or byte 7 differs from 0xD5. Otherwise it is low.
- R7: `rx_er` high on any edge that samples `rx_dv` high makes `frame_bad` high at that frame's end. `rx_er` while idle has no effect on any frame.
- R8: `frame_bad` is also high when the frame has fewer than 26 bytes, or when the frame size minus 26 differs from the length field.
- R9: `frame_count` increments by one, with wrap-around, in each cycle where `frame_end` is high. At all other times it holds.
- R10: After reset, `frame_end`, `pay_valid`, the status flags and `frame_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error indication |
| dst_addr | output | 48 | Captured destination address |
| src_addr | output | 48 | Captured source address |
| len_field | output | 16 | Captured length field |
| pay_data | output | 8 | Payload byte to client |
| pay_valid | output | 1 | Payload byte strobe |
| frame_end | output | 1 | One-cycle end-of-frame strobe |
| fcs_ok | output | 1 | Check sequence matched (valid with frame_end) |
| frame_bad | output | 1 | Line error, short frame or length mismatch |
| preamble_bad | output | 1 | Malformed preamble or start delimiter |
| frame_count | output | COUNT_W | Completed frame counter |

## Verification
The bench sends several kinds of frames. Back-to-back frames separated by a single idle cycle test whether the design confuses one frame's tail with the next frame's start; a design that got this wrong would merge them or lose the strobe. A corrupted check byte, a wrong preamble byte and a wrong delimiter each confirm that only the matching flag reacts. A design with the CRC window off by one byte, or with the check bytes in the wrong order, would clear `fcs_ok` on clean frames. A 20-byte frame, a zero-payload frame and a frame whose length field disagrees with its size probe the size rules. In these cases a wrong tail depth would leak check bytes to the client or drop the last payload byte. Error pulses both inside a frame and between frames show whether the error latch is cleared at frame start and ignored while idle.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam int SFD_IDX    = 7;
    localparam int DA_IDX     = 8;
    localparam int SA_IDX     = 14;
    localparam int LEN_IDX    = 20;
    localparam int PAY_IDX    = 22;
    localparam int FCS_LEN    = 4;
    localparam int CRC_START  = DA_IDX;
    localparam int MIN_FRAME  = PAY_IDX + FCS_LEN;

    localparam logic [7:0]  PRE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE = 8'hD5;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;

    // one byte of reflected CRC-32, least significant bit first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int b = 0; b < 8; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rx_tail_buf.sv
module rx_tail_buf #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift,
    input  logic [W-1:0]       din,
    output logic [W-1:0]       oldest,
    output logic [W*DEPTH-1:0] word
);
    logic [W-1:0] stg_q [DEPTH];
    logic [W-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d = stg_q;
        if (shift) begin
            stg_d[0] = din;
            for (int k = 1; k < DEPTH; k++) begin
                stg_d[k] = stg_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign oldest = stg_q[DEPTH-1];

    // newest byte in the top lane, oldest in the bottom lane
    for (genvar k = 0; k < DEPTH; k++) begin : g_lane
        assign word[(DEPTH-k)*W-1 -: W] = stg_q[k];
    end

endmodule

// File: rtl/rx_crc32.sv
module rx_crc32 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc
);
    import frame_rx_pkg::*;

    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (seed) begin
            crc_d = '1;
        end else if (en) begin
            crc_d = crc32_step(crc_q, din);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
    parameter int COUNT_W = 16,
    parameter int BCNT_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         rx_data,
    input  logic               rx_dv,
    input  logic               rx_er,
    input  logic [7:0]         tail_oldest,
    input  logic [31:0]        tail_word,
    input  logic [31:0]        crc_val,
    output logic               tail_shift,
    output logic               crc_seed,
    output logic               crc_en,
    output logic [47:0]        dst_addr,
    output logic [47:0]        src_addr,
    output logic [15:0]        len_field,
    output logic [7:0]         pay_data,
    output logic               pay_valid,
    output logic               frame_end,
    output logic               fcs_ok,
    output logic               frame_bad,
    output logic               preamble_bad,
    output logic [COUNT_W-1:0] frame_count
);
    import frame_rx_pkg::*;

    localparam logic [BCNT_W-1:0] BCNT_MAX = '1;

    typedef struct packed {
        logic               in_frame;
        logic [BCNT_W-1:0]  bcnt;
        logic               err_seen;
        logic               pre_err;
        logic [47:0]        dst;
        logic [47:0]        src;
        logic [15:0]        len;
        logic [7:0]         pay;
        logic               pay_v;
        logic               eof;
        logic               fcs_ok;
        logic               bad;
        logic               pre_bad;
        logic [COUNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [BCNT_W-1:0] idx;
    logic [31:0]       idx_w;
    logic [31:0]       size_w;
    logic              pre_hit;

    always_comb begin
        st_d       = st_q;
        st_d.pay_v = 1'b0;
        st_d.eof   = 1'b0;
        idx        = st_q.in_frame ? st_q.bcnt : '0;
        idx_w      = 32'(idx);
        size_w     = 32'(st_q.bcnt);
        pre_hit    = 1'b0;
        tail_shift = rx_dv;
        crc_seed   = rx_dv && !st_q.in_frame;
        crc_en     = rx_dv && (idx_w >= CRC_START + FCS_LEN);

        if (rx_dv) begin
            st_d.in_frame = 1'b1;
            st_d.bcnt     = (idx != BCNT_MAX) ? idx + 1'b1 : idx;
            if (idx_w < SFD_IDX)       pre_hit = (rx_data != PRE_BYTE);
            else if (idx_w == SFD_IDX) pre_hit = (rx_data != SFD_BYTE);
            st_d.err_seen = (st_q.in_frame && st_q.err_seen) || rx_er;
            st_d.pre_err  = (st_q.in_frame && st_q.pre_err) || pre_hit;
            if (idx_w >= DA_IDX && idx_w < SA_IDX)   st_d.dst = {st_q.dst[39:0], rx_data};
            if (idx_w >= SA_IDX && idx_w < LEN_IDX)  st_d.src = {st_q.src[39:0], rx_data};
            if (idx_w >= LEN_IDX && idx_w < PAY_IDX) st_d.len = {st_q.len[7:0], rx_data};
            if (idx_w >= PAY_IDX + FCS_LEN) begin
                st_d.pay_v = 1'b1;
                st_d.pay   = tail_oldest;
            end
        end else if (st_q.in_frame) begin
            st_d.in_frame = 1'b0;
            st_d.eof      = 1'b1;
            st_d.cnt      = st_q.cnt + 1'b1;
            st_d.fcs_ok   = (tail_word == ~crc_val);
            st_d.bad      = st_q.err_seen || (size_w < MIN_FRAME)
                            || ((size_w - MIN_FRAME) != 32'(st_q.len));
            st_d.pre_bad  = st_q.pre_err;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_addr     = st_q.dst;
    assign src_addr     = st_q.src;
    assign len_field    = st_q.len;
    assign pay_data     = st_q.pay;
    assign pay_valid    = st_q.pay_v;
    assign frame_end    = st_q.eof;
    assign fcs_ok       = st_q.fcs_ok;
    assign frame_bad    = st_q.bad;
    assign preamble_bad = st_q.pre_bad;
    assign frame_count  = st_q.cnt;

endmodule

// File: rtl/gmii_frame_rx.sv
module gmii_frame_rx #(
    parameter int COUNT_W = 16,
    parameter int BCNT_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         rx_data,
    input  logic               rx_dv,
    input  logic               rx_er,
    output logic [47:0]        dst_addr,
    output logic [47:0]        src_addr,
    output logic [15:0]        len_field,
    output logic [7:0]         pay_data,
    output logic               pay_valid,
    output logic               frame_end,
    output logic               fcs_ok,
    output logic               frame_bad,
    output logic               preamble_bad,
    output logic [COUNT_W-1:0] frame_count
);
    import frame_rx_pkg::*;

    logic        tail_shift;
    logic [7:0]  tail_oldest;
    logic [31:0] tail_word;
    logic        crc_seed;
    logic        crc_en;
    logic [31:0] crc_val;

    rx_tail_buf #(.W(8), .DEPTH(FCS_LEN)) u_tail (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (tail_shift),
        .din    (rx_data),
        .oldest (tail_oldest),
        .word   (tail_word)
    );

    rx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (crc_seed),
        .en    (crc_en),
        .din   (tail_oldest),
        .crc   (crc_val)
    );

    rx_frame_ctrl #(.COUNT_W(COUNT_W), .BCNT_W(BCNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_data      (rx_data),
        .rx_dv        (rx_dv),
        .rx_er        (rx_er),
        .tail_oldest  (tail_oldest),
        .tail_word    (tail_word),
        .crc_val      (crc_val),
        .tail_shift   (tail_shift),
        .crc_seed     (crc_seed),
        .crc_en       (crc_en),
        .dst_addr     (dst_addr),
        .src_addr     (src_addr),
        .len_field    (len_field),
        .pay_data     (pay_data),
        .pay_valid    (pay_valid),
        .frame_end    (frame_end),
        .fcs_ok       (fcs_ok),
        .frame_bad    (frame_bad),
        .preamble_bad (preamble_bad),
        .frame_count  (frame_count)
    );

endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
    parameter int COUNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_dv,
    input logic               pay_valid,
    input logic               frame_end,
    input logic [COUNT_W-1:0] frame_count
);
    // R2
    eof_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    // R2
    eof_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !$past(rx_dv));

    // R4
    pay_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(rx_dv));

    // R4
    pay_eof_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pay_valid && frame_end));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> frame_count == $past(frame_count) + 1'b1);

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |-> $stable(frame_count));

endmodule

bind gmii_frame_rx frame_rx_chk #(.COUNT_W(COUNT_W)) u_frame_rx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_dv       (rx_dv),
    .pay_valid   (pay_valid),
    .frame_end   (frame_end),
    .frame_count (frame_count)
);

// File: tb/tb_gmii_frame_rx.sv
module tb_gmii_frame_rx;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    rx_data;
    logic          rx_dv;
    logic          rx_er;
    logic [47:0]   dst_addr;
    logic [47:0]   src_addr;
    logic [15:0]   len_field;
    logic [7:0]    pay_data;
    logic          pay_valid;
    logic          frame_end;
    logic          fcs_ok;
    logic          frame_bad;
    logic          preamble_bad;
    logic [CW-1:0] frame_count;

    always #5 clk = ~clk;

    gmii_frame_rx #(.COUNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er),
        .dst_addr(dst_addr), .src_addr(src_addr), .len_field(len_field),
        .pay_data(pay_data), .pay_valid(pay_valid), .frame_end(frame_end),
        .fcs_ok(fcs_ok), .frame_bad(frame_bad), .preamble_bad(preamble_bad),
        .frame_count(frame_count)
    );

    typedef struct {
        logic [47:0] dst;
        logic [47:0] src;
        logic [15:0] len;
        bit          full;
        bit          fcs;
        bit          bad;
        bit          pre;
        int          count;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] pay_q[$];
    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int nframes = 0;
    bit done   = 0;
    bit prev_end = 0;

    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
        end
        return r;
    endfunction

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (pay_valid) begin
                    if (pay_q.size() == 0) begin
                        check(0, "R4", "unexpected payload byte", pay_data, 0);
                    end else begin
                        logic [7:0] e;
                        e = pay_q.pop_front();
                        check(pay_data == e, "R4", "payload byte", pay_data, e);
                    end
                end
                if (frame_end) begin
                    check(!prev_end, "R2", "strobe longer than one cycle", 1, 0);
                    if (exp_q.size() == 0) begin
                        check(0, "R2", "unexpected frame end", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(cyc == e.cyc, "R2", "end strobe cycle", cyc, e.cyc);
                        check(dst_addr == e.dst, "R1 R3", "dst_addr", dst_addr, e.dst);
                        check(src_addr == e.src, "R3", "src_addr", src_addr, e.src);
                        if (e.full) begin
                            check(len_field == e.len, "R3", "len_field", len_field, e.len);
                            check(fcs_ok == e.fcs, "R5", "fcs_ok", fcs_ok, e.fcs);
                        end
                        check(frame_bad == e.bad, e.tag, "frame_bad", frame_bad, e.bad);
                        check(preamble_bad == e.pre, "R6", "preamble_bad", preamble_bad, e.pre);
                        check(int'(frame_count) == e.count, "R9", "frame_count", frame_count, e.count);
                    end
                end
                prev_end = frame_end;
            end
        end
    end

    // driver: builds a frame, pushes expectations, drives the bytes
    task automatic send_frame(input int pay_n, input int len_val, input int trunc,
                              input bit bad_fcs, input int err_at, input int pre_at,
                              input logic [7:0] pre_val, input bit exp_bad, input bit exp_pre,
                              input string tag, input int gap, input bit idle_err);
        logic [7:0]  fb [0:1599];
        logic [31:0] c;
        logic [47:0] da, sa;
        int n;
        exp_t e;
        nframes++;
        da = 48'h0A00_0000_0000 + 48'(nframes * 257);
        sa = 48'h5C00_0000_1000 + 48'(nframes * 4099);
        for (int i = 0; i < 7; i++) fb[i] = 8'h55;
        fb[7] = 8'hD5;
        for (int i = 0; i < 6; i++) begin
            fb[8 + i]  = da[47 - 8*i -: 8];
            fb[14 + i] = sa[47 - 8*i -: 8];
        end
        fb[20] = 8'(len_val >> 8);
        fb[21] = 8'(len_val);
        for (int k = 0; k < pay_n; k++) fb[22 + k] = 8'(nframes * 13 + k * 7 + 1);
        c = 32'hFFFF_FFFF;
        for (int i = 8; i < 22 + pay_n; i++) c = ref_crc(c, fb[i]);
        c = ~c;
        for (int j = 0; j < 4; j++) fb[22 + pay_n + j] = c[8*j +: 8];
        if (bad_fcs) fb[22 + pay_n + 2] = fb[22 + pay_n + 2] ^ 8'h10;
        if (pre_at >= 0) fb[pre_at] = pre_val;
        n = (trunc >= 0) ? trunc : 26 + pay_n;
        for (int i = 22; i <= n - 5; i++) pay_q.push_back(fb[i]);

        e.dst = da; e.src = sa; e.len = 16'(len_val);
        e.full = (trunc < 0); e.fcs = !bad_fcs; e.bad = exp_bad; e.pre = exp_pre;
        e.count = nframes; e.tag = tag;

        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_dv   = 1'b1;
            rx_data = fb[i];
            rx_er   = (i == err_at);
        end
        @(negedge clk);
        rx_dv   = 1'b0;
        rx_er   = 1'b0;
        rx_data = 8'h00;
        e.cyc = cyc + 1;
        exp_q.push_back(e);
        for (int g = 1; g < gap; g++) begin
            @(negedge clk);
            rx_er = idle_err;
        end
        rx_er = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; rx_dv = 1'b0; rx_er = 1'b0; rx_data = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R10 reset state
        check(frame_end == 0, "R10", "frame_end after reset", frame_end, 0);
        check(pay_valid == 0, "R10", "pay_valid after reset", pay_valid, 0);
        check(frame_count == 0, "R10", "frame_count after reset", frame_count, 0);
        check({fcs_ok, frame_bad, preamble_bad} == 3'b000, "R10", "flags after reset",
              {fcs_ok, frame_bad, preamble_bad}, 0);
        @(negedge clk);

        // R1 R5 clean minimum-size payload
        send_frame(46, 46, -1, 0, -1, -1, 8'h00, 0, 0, "R8", 3, 0);
        // R2 back-to-back with one idle cycle
        send_frame(60, 60, -1, 0, -1, -1, 8'h00, 0, 0, "R8", 1, 0);
        // R5 corrupted check byte
        send_frame(46, 46, -1, 1, -1, -1, 8'h00, 0, 0, "R8", 3, 0);
        // R7 line error inside the frame, then error pulses while idle
        send_frame(46, 46, -1, 0, 30, -1, 8'h00, 1, 0, "R7", 6, 1);
        // R7 idle errors must not mark this frame
        send_frame(10, 10, -1, 0, -1, -1, 8'h00, 0, 0, "R7", 2, 0);
        // R8 length field disagrees with size
        send_frame(46, 50, -1, 0, -1, -1, 8'h00, 1, 0, "R8", 2, 0);
        // R8 short frame of 20 bytes
        send_frame(46, 46, 20, 0, -1, -1, 8'h00, 1, 0, "R8", 3, 0);
        // R6 bad preamble byte
        send_frame(46, 46, -1, 0, -1, 3, 8'h54, 0, 1, "R8", 2, 0);
        // R6 bad start delimiter
        send_frame(46, 46, -1, 0, -1, 7, 8'hD4, 0, 1, "R8", 2, 0);
        // R8 zero payload, exact minimum frame
        send_frame(0, 0, -1, 0, -1, -1, 8'h00, 0, 0, "R8", 4, 0);

        repeat (20) @(negedge clk);
        check(pay_q.size() == 0, "R4", "payload bytes left unseen", pay_q.size(), 0);
        check(exp_q.size() == 0, "R2", "frame ends left unseen", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule